// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating analog-to-digital converter. After a start pulse it first closes a discharge switch so the external integrator is emptied. It then connects the integrator to the unknown input for a fixed, programmable span of clocks. Last, it connects the integrator to the negative reference and counts until the external comparator reports that the integrator output has come back to zero. The count reached at that moment is the conversion result. The result is proportional to the ratio of input to reference. It depends on neither the integrator time constant nor the clock period.

The integrate span is a whole multiple of 2^N clocks, with the multiple set by a small configuration input. This lets the span be matched to one or more mains periods so that line pickup averages out. During de-integration the tally advances once every (multiple) clocks. The result therefore stays N bits wide and keeps the same scale for every multiple. If the comparator never trips, the result saturates and an overrange flag is raised. The analog integrator and comparator sit outside the block.

Top module: `dslope_seq`

## Requirements
- R1: After reset all three switch selects are low, busy and done are low, and the result and overrange outputs are zero.
- R2: A start pulse while idle closes only the discharge switch for exactly rst_len_i + 1 clock cycles.
- R3: The input switch closes directly after discharge and stays closed for exactly (int_mult_i + 1) × 2^N cycles.
- R4: The reference switch closes directly after integration, and no two switch selects are ever high together.
- R5: De-integration ends on the first de-integrate cycle j (j counted from 0) on which cmp_pos_i is low. The result is then floor(j / (int_mult_i + 1)) and overrange is 0.
- R6: If cmp_pos_i is still high on the cycle that would complete tally step 2^N, the conversion ends on that cycle. The result is then all ones and overrange is 1, so the reference switch is closed for at most (int_mult_i + 1) × 2^N cycles.
- R7: done_o is high for exactly one cycle, in the cycle after the last de-integrate cycle, and busy_o is low in that cycle.
- R8: A start pulse while busy is ignored. The running conversion neither restarts nor lengthens, and busy stays high until it ends.
- R9: int_mult_i and rst_len_i are captured on the accepted start. Changing them during a conversion has no effect on that conversion.
- R10: result_o and ovr_o change only on the edge that raises done_o and hold their values until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion start pulse |
| cmp_pos_i | input | 1 | High while the integrator output is above zero |
| int_mult_i | input | MULT_W | Integrate span multiple minus one |
| rst_len_i | input | RST_W | Discharge length minus one |
| sw_zero_o | output | 1 | Closes the integrator discharge switch |
| sw_in_o | output | 1 | Connects the integrator to the input |
| sw_ref_o | output | 1 | Connects the integrator to the negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Comparator did not trip within the tally range |
| result_o | output | CNT_W | Conversion result |

## Verification
The hardest condition to reach is the boundary between a full-scale reading and overrange. Here the comparator must stay high through the very cycle that completes the last tally step, with a prescaled tally under every span multiple. A behavioural integrator in the bench accumulates the input and removes the reference each clock, following the switch selects. Sweeping the input from zero to past the reference, over all multiples and two reference values, lands conversions on both sides of that edge and on exact-ratio points. A second start and changed configuration are injected during each conversion to show they are ignored.

// File: rtl/dslope_pkg.sv
// Shared types and width helpers for the dual-slope sequencer.
package dslope_pkg;

    // Conversion phase; order is the sequence a conversion walks through.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ZERO  = 2'd1,
        PH_INTEG = 2'd2,
        PH_DEINT = 2'd3
    } phase_e;

    // Width of the shared phase counter: must hold the longest integrate
    // span ((2^MULT_W) << CNT_W) and the longest discharge count.
    function automatic int span_width(int cnt_w, int mult_w, int rst_w);
        int integ_w;
        integ_w = cnt_w + mult_w + 1;
        return (integ_w > rst_w) ? integ_w : rst_w;
    endfunction

endpackage

// File: rtl/dslope_span_counter.sv
// Phase-length counter shared by the discharge and integrate phases.
// Assumes: clr_i has priority; counting only while en_i is high.
module dslope_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] count_o
);

    // Count cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= '0;
        end else if (en_i) begin
            count_o <= count_o + W'(1);
        end
    end

endmodule

// File: rtl/dslope_phase_ctrl.sv
// Phase sequencer: idle -> discharge -> integrate -> de-integrate -> idle.
// Captures the configuration on an accepted start and decides phase ends
// from the shared counter; de-integrate end comes from the tally block.
// Assumes: start_i is only acted on in idle.
module dslope_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int MULT_W = 3,
    parameter int RST_W  = 6,
    parameter int SPAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MULT_W-1:0] int_mult_i,
    input  logic [RST_W-1:0]  rst_len_i,
    input  logic [SPAN_W-1:0] span_cnt_i,
    input  logic              deint_end_i,
    output phase_e            phase_o,
    output logic              span_clr_o,
    output logic [MULT_W-1:0] mult_q_o
);

    phase_e             phase_nxt;
    logic [RST_W-1:0]   rlen_q;
    logic [SPAN_W-1:0]  integ_len;
    logic               zero_last;
    logic               integ_last;

    // Integrate span in clocks: (multiple + 1) * 2^CNT_W.
    always_comb begin
        integ_len  = (SPAN_W'(mult_q_o) + SPAN_W'(1)) << CNT_W;
        zero_last  = (span_cnt_i == SPAN_W'(rlen_q));
        integ_last = (span_cnt_i == integ_len - SPAN_W'(1));
    end

    // Next-phase decision.
    always_comb begin
        phase_nxt = phase_o;
        unique case (phase_o)
            PH_IDLE:  if (start_i)     phase_nxt = PH_ZERO;
            PH_ZERO:  if (zero_last)   phase_nxt = PH_INTEG;
            PH_INTEG: if (integ_last)  phase_nxt = PH_DEINT;
            PH_DEINT: if (deint_end_i) phase_nxt = PH_IDLE;
            default:                   phase_nxt = PH_IDLE;
        endcase
        span_clr_o = (phase_nxt != phase_o);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_IDLE;
        else        phase_o <= phase_nxt;
    end

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q_o <= '0;
            rlen_q   <= '0;
        end else if (phase_o == PH_IDLE && start_i) begin
            mult_q_o <= int_mult_i;
            rlen_q   <= rst_len_i;
        end
    end

endmodule

// File: rtl/dslope_deint_tally.sv
// De-integrate tally: a prescaler divides the clock by (multiple + 1) and
// each wrap adds one step. Ends on a low comparator or on saturation,
// then loads the result, overrange flag and a one-cycle done pulse.
// Assumes: active_i is high only during the de-integrate phase.
module dslope_deint_tally #(
    parameter int CNT_W  = 12,
    parameter int MULT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              cmp_pos_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic              end_o,
    output logic [CNT_W-1:0]  result_o,
    output logic              ovr_o,
    output logic              done_o
);

    logic [MULT_W-1:0] pre_q;
    logic [CNT_W-1:0]  tally_q;
    logic              step;
    logic              sat;

    // Step and termination decode.
    always_comb begin
        step  = active_i && cmp_pos_i && (pre_q == mult_i);
        sat   = step && (&tally_q);
        end_o = active_i && (!cmp_pos_i || sat);
    end

    // Prescaler and tally, held at zero outside de-integration.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            pre_q   <= '0;
            tally_q <= '0;
        end else if (cmp_pos_i) begin
            if (pre_q == mult_i) begin
                pre_q <= '0;
                if (!sat) tally_q <= tally_q + CNT_W'(1);
            end else begin
                pre_q <= pre_q + MULT_W'(1);
            end
        end
    end

    // Result capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= end_o;
            if (end_o) begin
                result_o <= sat ? '1 : tally_q;
                ovr_o    <= sat;
            end
        end
    end

endmodule

// File: rtl/dslope_seq.sv
// Dual-slope conversion sequencer top. Drives the integrator switch
// selects from the current phase and reports the tally as the result.
// Assumes: cmp_pos_i is synchronous to clk and high while the integrator
// output is above zero.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int MULT_W = 3,
    parameter int RST_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_pos_i,
    input  logic [MULT_W-1:0] int_mult_i,
    input  logic [RST_W-1:0]  rst_len_i,
    output logic              sw_zero_o,
    output logic              sw_in_o,
    output logic              sw_ref_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ovr_o,
    output logic [CNT_W-1:0]  result_o
);

    localparam int SPAN_W = span_width(CNT_W, MULT_W, RST_W);

    phase_e             phase;
    logic               span_clr;
    logic [SPAN_W-1:0]  span_cnt;
    logic [MULT_W-1:0]  mult_q;
    logic               deint_end;

    dslope_phase_ctrl #(
        .CNT_W (CNT_W),
        .MULT_W(MULT_W),
        .RST_W (RST_W),
        .SPAN_W(SPAN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .int_mult_i (int_mult_i),
        .rst_len_i  (rst_len_i),
        .span_cnt_i (span_cnt),
        .deint_end_i(deint_end),
        .phase_o    (phase),
        .span_clr_o (span_clr),
        .mult_q_o   (mult_q)
    );

    dslope_span_counter #(
        .W(SPAN_W)
    ) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (span_clr),
        .en_i   (phase != PH_IDLE),
        .count_o(span_cnt)
    );

    dslope_deint_tally #(
        .CNT_W (CNT_W),
        .MULT_W(MULT_W)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (phase == PH_DEINT),
        .cmp_pos_i(cmp_pos_i),
        .mult_i   (mult_q),
        .end_o    (deint_end),
        .result_o (result_o),
        .ovr_o    (ovr_o),
        .done_o   (done_o)
    );

    // Switch selects and busy decode from the phase.
    always_comb begin
        sw_zero_o = (phase == PH_ZERO);
        sw_in_o   = (phase == PH_INTEG);
        sw_ref_o  = (phase == PH_DEINT);
        busy_o    = (phase != PH_IDLE);
    end

endmodule

// File: rtl/dslope_seq_chk.sv
// Protocol checker for dslope_seq, attached through bind.
module dslope_seq_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sw_zero_o,
    input logic             sw_in_o,
    input logic             sw_ref_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             ovr_o,
    input logic [CNT_W-1:0] result_o
);

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_zero_o, sw_in_o, sw_ref_o})); // R4

    AST_INT_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_in_o) |-> $past(sw_zero_o)); // R3

    AST_REF_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref_o) |-> $past(sw_in_o)); // R4

    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (&result_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sw_ref_o && start_i) |=> busy_o); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovr_o))); // R10

endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sw_zero_o(sw_zero_o),
    .sw_in_o  (sw_in_o),
    .sw_ref_o (sw_ref_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ovr_o    (ovr_o),
    .result_o (result_o)
);

// File: tb/dslope_seq_bench.sv
// Sweep bench with a behavioural integrator driven by the switch selects.
module dslope_seq_bench;

    localparam int CLK_P  = 10;
    localparam int CNT_W  = 4;
    localparam int MULT_W = 2;
    localparam int RST_W  = 3;
    localparam int FULL   = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              cmp_pos_i;
    logic [MULT_W-1:0] int_mult_i = '0;
    logic [RST_W-1:0]  rst_len_i = '0;
    logic              sw_zero_o, sw_in_o, sw_ref_o, busy_o, done_o, ovr_o;
    logic [CNT_W-1:0]  result_o;

    int checks = 0;
    int fails  = 0;
    int vin    = 0;
    int vref   = 1;
    int integ  = 0;

    always #(CLK_P/2) clk = ~clk;

    dslope_seq #(.CNT_W(CNT_W), .MULT_W(MULT_W), .RST_W(RST_W)) u_dslope_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_pos_i(cmp_pos_i),
        .int_mult_i(int_mult_i), .rst_len_i(rst_len_i),
        .sw_zero_o(sw_zero_o), .sw_in_o(sw_in_o), .sw_ref_o(sw_ref_o),
        .busy_o(busy_o), .done_o(done_o), .ovr_o(ovr_o), .result_o(result_o)
    );

    // Behavioural integrator: discharge, accumulate input, remove reference.
    always @(posedge clk) begin
        if (sw_zero_o)     integ <= 0;
        else if (sw_in_o)  integ <= integ + vin;
        else if (sw_ref_o) integ <= integ - vref;
    end
    assign cmp_pos_i = (integ > 0);

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int vin_v, input int vref_v, input int mult, input int rstc);
        int nz, ni, nr, cyc, held, stayed, m, len, j0, e_ovr, e_res, e_ref;
        logic [CNT_W-1:0] prev_res;
        logic             prev_ovr;
        vin = vin_v;
        vref = vref_v;
        int_mult_i = MULT_W'(mult);
        rst_len_i = RST_W'(rstc);
        prev_res = result_o;
        prev_ovr = ovr_o;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        nz = 0; ni = 0; nr = 0; cyc = 0; held = 1; stayed = 1;
        while (!done_o && cyc < 2000) begin
            nz += int'(sw_zero_o);
            ni += int'(sw_in_o);
            nr += int'(sw_ref_o);
            if (!busy_o) stayed = 0;
            if (result_o != prev_res || ovr_o != prev_ovr) held = 0;
            if (cyc == rstc + 3) begin
                start_i = 1'b1;                       // R8 injected start
                int_mult_i = ~MULT_W'(mult);          // R9 late change
                rst_len_i = ~RST_W'(rstc);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        m = mult + 1;
        len = m * FULL;
        j0 = (len * vin_v + vref_v - 1) / vref_v;
        e_ovr = (j0 >= len) ? 1 : 0;
        e_res = e_ovr ? (FULL - 1) : (j0 / m);
        e_ref = e_ovr ? len : (j0 + 1);
        check_eq("R7 done seen", int'(done_o), 1);
        check_eq("R7 busy low at done", int'(busy_o), 0);
        check_eq("R2 discharge cycles", nz, rstc + 1);
        check_eq("R3 R9 integrate cycles", ni, len);
        check_eq("R5 R6 de-integrate cycles", nr, e_ref);
        check_eq("R5 result", int'(result_o), e_res);
        check_eq("R6 overrange", int'(ovr_o), e_ovr);
        check_eq("R8 busy held and no restart", stayed * cyc, rstc + 1 + len + e_ref);
        check_eq("R10 result held while busy", held, 1);
        @(negedge clk);
        check_eq("R7 done single cycle", int'(done_o), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 switches open", int'({sw_zero_o, sw_in_o, sw_ref_o}), 0);
        check_eq("R1 busy low", int'(busy_o), 0);
        check_eq("R1 done low", int'(done_o), 0);
        check_eq("R1 result zero", int'(result_o), 0);
        check_eq("R1 overrange zero", int'(ovr_o), 0);
        for (int r = 0; r < 2; r++) begin
            for (int mu = 0; mu < (1 << MULT_W); mu++) begin
                for (int v = 0; v <= FULL + 1; v++) begin
                    run_conv(v, (r == 0) ? FULL : 9, mu, (v + mu) % (1 << RST_W));
                end
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule